// File: doc/BRIEF.md
# Wakeup interrupt polarity converter

This block is a per-pin front end placed between asynchronous wake sources and a downstream interrupt controller. That controller can only take rising-edge or active-high requests. For each pin, the block synchronizes the input and applies a programmable trigger type. It then drives a request that is always active-high. In level modes the request is a level. In edge modes it is a single-cycle pulse. Active-low and falling-edge sources are inverted before detection. A dual-edge source gives one pulse for each transition of its input.

Software reaches the block through a small single-cycle register port. It sets one enable bit per pin and one trigger code per pin. When a trigger code is written, the edge detector of that pin is reseeded. This means a polarity change on a steady input never reaches the controller as a request. There is one design module. The pin count and the register bases are parameters.

Top module: `wake_polarity_norm`

## Requirements
- R1: After reset every request output is 0, every enable bit reads 0 and every trigger code reads 3'b100 (level, active-high).
- R2: The enable bit of pin n is bit n%32 of the word at byte address EN_BASE (0x10) + 4*(n/32). A read returns the stored bits, and bits that belong to no pin read 0.
- R3: The trigger code of pin n is held in bits [2:0] of the word at CFG_BASE (0x110) + 4*n. A read returns the stored code in [2:0] and 0 in every other bit.
- R4: With code 3'b100, the request of an enabled pin equals its input, 3 clock cycles after the input changes.
- R5: With code 3'b000, the request of an enabled pin equals the inverted input, with the same 3-cycle latency.
- R6: With code 3'b110, each 0-to-1 input transition gives a request pulse that is exactly 1 cycle wide and starts 3 cycles after the transition. A 1-to-0 transition gives no pulse.
- R7: With code 3'b010, each 1-to-0 input transition gives a 1-cycle request pulse 3 cycles after the transition. A 0-to-1 transition gives no pulse.
- R8: With code 3'b111, every input transition in either direction gives a 1-cycle request pulse 3 cycles after it.
- R9: Writing a new edge code (010, 110 or 111) to a pin whose input is steady produces no request pulse.
- R10: A pin whose enable bit is 0 never raises its request, whatever its input does.
- R11: The codes 001, 011 and 101 raise no request on an enabled pin, whatever its input does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| wake_in | input | NPINS | Asynchronous wake sources, one per pin |
| req_out | output | NPINS | Normalized requests to the interrupt controller |

## Verification
A stale edge-history flop shows up at the ports as a pulse that is too wide, a pulse that is missing, or a stray pulse. It appears exactly 3 cycles after the input change or 2 cycles after the code write that exposed it. The sweep therefore samples every cycle inside that window. A wrong trigger decode shows as the wrong level or pulse in the first sampled cycle after the synchronizer delay, for one of the eight codes. The sweep covers all eight codes on pins in both enable words, and it checks every other pin's request at the same time. A misplaced enable or code field therefore shows up as a request on the wrong pin, or as a readback mismatch.

// File: rtl/wake_polarity_norm.sv
module wake_polarity_norm #(
  parameter int NPINS = 40,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] EN_BASE = 'h10,
  parameter logic [ADDR_W-1:0] CFG_BASE = 'h110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NPINS-1:0]  wake_in,
  output logic [NPINS-1:0]  req_out
);
  localparam int EN_WORDS = (NPINS + 31) / 32;
  localparam logic [2:0] RESET_CODE = 3'b100;

  logic [NPINS-1:0]   en_q;
  logic [3*NPINS-1:0] cfg_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (reg_we)
      for (int n = 0; n < NPINS; n++)
        if (reg_addr == EN_BASE + ADDR_W'(4 * (n / 32))) en_q[n] <= reg_wdata[n % 32];
  end

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < EN_WORDS; w++)
      if (reg_addr == EN_BASE + ADDR_W'(4 * w))
        for (int b = 0; b < 32; b++)
          if (w * 32 + b < NPINS) reg_rdata[b] = en_q[w * 32 + b];
    for (int n = 0; n < NPINS; n++)
      if (reg_addr == CFG_BASE + ADDR_W'(4 * n)) reg_rdata[2:0] = cfg_flat[3 * n +: 3];
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [2:0] cfg_r;
    logic s1_r, s2_r, prev_r, req_r;
    logic hit, valid, level, dual, pol, fire;

    assign hit   = reg_we && (reg_addr == CFG_BASE + ADDR_W'(4 * n));
    assign valid = (cfg_r == 3'b000) || (cfg_r == 3'b010) || (cfg_r == 3'b100) ||
                   (cfg_r == 3'b110) || (cfg_r == 3'b111);
    assign level = ~cfg_r[1];
    assign dual  = (cfg_r == 3'b111);
    assign pol   = s2_r ^ ~cfg_r[2];
    assign fire  = level ? pol : (dual ? (pol ^ prev_r) : (pol & ~prev_r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_r  <= RESET_CODE;
        s1_r   <= 1'b0;
        s2_r   <= 1'b0;
        prev_r <= 1'b0;
        req_r  <= 1'b0;
      end else begin
        s1_r   <= wake_in[n];
        s2_r   <= s1_r;
        prev_r <= hit ? (s1_r ^ ~reg_wdata[2]) : pol;
        req_r  <= en_q[n] & valid & fire;
        if (hit) cfg_r <= reg_wdata[2:0];
      end
    end

    assign req_out[n]          = req_r;
    assign cfg_flat[3*n +: 3]  = cfg_r;

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[n] |=> !req_r);
    a_r11_bad_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> !req_r);
    a_r6_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (req_r && (cfg_r == 3'b110 || cfg_r == 3'b010)) |=> !req_r);
    a_r9_no_cfg_glitch: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && reg_wdata[1]) |-> ##2 !req_r);
  end
endmodule

// File: tb/test_wake_polarity_norm.sv
`timescale 1ns/1ps
module test_wake_polarity_norm;
  localparam int NP = 40;
  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NP-1:0] wake_in = '0, req_out;
  int checks = 0, errors = 0;

  wake_polarity_norm i_wake_polarity_norm (.clk, .rst_n, .reg_we, .reg_addr,
    .reg_wdata, .reg_rdata, .wake_in, .req_out);

  always #5 clk = ~clk;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic expv(input int code, input logic prv, input logic cur, input logic first);
    case (code)
      0: return !cur;
      4: return cur;
      6: return first & !prv & cur;
      2: return first & prv & !cur;
      7: return first & (prv ^ cur);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      0: return "R5"; 2: return "R7"; 4: return "R4"; 6: return "R6"; 7: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [11:0] en_addr(input int p); return 12'h10 + 12'(4 * (p / 32)); endfunction
  function automatic logic [11:0] cfg_addr(input int p); return 12'h110 + 12'(4 * p); endfunction
  function automatic logic [63:0] at(input logic v, input int p); return 64'(v) << p; endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int pins[5] = '{0, 7, 31, 32, 39};
    step(2); rst_n = 1; step(1);
    // R1 reset state
    chk(64'(req_out), 0, "R1 req");
    for (int n = 0; n < NP; n++) begin rd(cfg_addr(n), d); chk(64'(d), 4, "R1 cfg"); end
    rd(12'h10, d); chk(64'(d), 0, "R1 en0");
    rd(12'h14, d); chk(64'(d), 0, "R1 en1");
    // R2 enable packing
    wr(12'h10, 32'hA5A5_A5A5); rd(12'h10, d); chk(64'(d), 64'hA5A5_A5A5, "R2 word0");
    wr(12'h14, 32'hFFFF_FFFF); rd(12'h14, d); chk(64'(d), 64'hFF, "R2 word1 unused bits");
    wr(12'h10, 0); wr(12'h14, 0);
    // R3 code fields
    for (int n = 0; n < NP; n++) wr(cfg_addr(n), 32'hFFFF_FFF8 | 32'(n % 8));
    for (int n = 0; n < NP; n++) begin rd(cfg_addr(n), d); chk(64'(d), 64'(n % 8), "R3 readback"); end
    for (int n = 0; n < NP; n++) wr(cfg_addr(n), 4);

    // sweep of all codes on several pins; R4..R8, R10, R11
    foreach (pins[i]) begin
      for (int c = 0; c < 8; c++) begin
        int p = pins[i];
        wake_in = '0;
        wr(cfg_addr(p), 32'(c));
        wr(en_addr(p), 32'(1) << (p % 32));
        step(4); chk(64'(req_out), at(expv(c, 0, 0, 0), p), tag_of(c));
        wake_in[p] = 1;
        step(3); chk(64'(req_out), at(expv(c, 0, 1, 1), p), tag_of(c));
        step(1); chk(64'(req_out), at(expv(c, 1, 1, 0), p), tag_of(c));
        wake_in[p] = 0;
        step(3); chk(64'(req_out), at(expv(c, 1, 0, 1), p), tag_of(c));
        step(1); chk(64'(req_out), at(expv(c, 0, 0, 0), p), tag_of(c));
        wr(en_addr(p), 0);
        step(1); chk(64'(req_out), 0, "R10 after disable");
        wake_in[p] = 1;
        step(3); chk(64'(req_out), 0, "R10 rise disabled");
        wake_in[p] = 0;
        step(3); chk(64'(req_out), 0, "R10 fall disabled");
        step(1);
      end
      wr(cfg_addr(pins[i]), 4);
    end

    // R9: code change on a steady input
    wake_in = '0; wake_in[3] = 1;
    wr(cfg_addr(3), 2); wr(en_addr(3), 32'h8); step(4);
    chk(64'(req_out), 0, "R9 settle high falling");
    wr(cfg_addr(3), 6);
    for (int k = 0; k < 4; k++) begin chk(64'(req_out), 0, "R9 falling->rising"); step(1); end
    wr(cfg_addr(3), 7);
    for (int k = 0; k < 4; k++) begin chk(64'(req_out), 0, "R9 rising->dual"); step(1); end
    wake_in[3] = 0; step(3);
    chk(64'(req_out), at(1, 3), "R8 real edge after reseed");
    step(1);
    wr(cfg_addr(3), 6); step(2);
    wr(cfg_addr(3), 2);
    for (int k = 0; k < 4; k++) begin chk(64'(req_out), 0, "R9 rising->falling low"); step(1); end
    wake_in[3] = 1; step(4);
    wake_in[3] = 0; step(3);
    chk(64'(req_out), at(1, 3), "R7 real falling after reseed");
    step(1); chk(64'(req_out), 0, "R7 pulse width");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule